// File: doc/BRIEF.md
# Two-Write Two-Read XOR-Coded Memory

This block is a synchronous memory with two independent write ports and two independent read ports, meant for register files and shared buffers that need more ports than a single dual-port RAM gives. Each write port owns a group of single-write, single-read RAM copies. A write does not store its value directly. It stores the value XORed with what the other port's group holds at that address. A read fetches the word from both groups and XORs them, and the encoding cancels out. No record of which port wrote last is kept, and there is no bank-select multiplexer on the read side.

To encode a write, the block must first read the other group, so each write spends one cycle fetching the old word and a second cycle committing the encoded word. This path is pipelined, so both ports can accept a write on every cycle. Bypass logic covers the cycle in which a write is accepted but not yet committed. It applies to reads and to the other port's encoding. Writes from both ports to one address in the same cycle are not permitted, and their result is undefined. Depth and word width are parameters.

Top module: `xor_mp_mem`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released, both read outputs are zero. Reset does not alter stored words. Locations never written since power-up read as zero.
- R2: Each read port samples its own address on a rising edge, and the word appears on its data output right after that same edge. The output holds until the next edge.
- R3: A word written through either write port can be read back on both read ports.
- R4: A read sampled on the edge after a write to the same address was accepted returns the newly written word.
- R5: A read sampled on the same edge at which a write to that address is accepted returns the word held before that write.
- R6: Both write ports accept a write on every edge without stalling, and every write lands, as long as the two ports use different addresses within each cycle.
- R7: When the two ports write one address on consecutive edges, the later write's value is the one read back afterwards.
- R8: With a write enable low, that port's address and data are ignored, and no stored word changes.
- R9: A write changes only its own address. This includes address 0 and address DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of pipeline and outputs |
| wr0_en | input | 1 | Write request on port 0 |
| wr0_addr | input | ADDR_W | Write address, port 0 |
| wr0_data | input | DATA_W | Write data, port 0 |
| wr1_en | input | 1 | Write request on port 1 |
| wr1_addr | input | ADDR_W | Write address, port 1 |
| wr1_data | input | DATA_W | Write data, port 1 |
| rd0_addr | input | ADDR_W | Read address, port 0 |
| rd0_data | output | DATA_W | Read data, port 0, one edge after address |
| rd1_addr | input | ADDR_W | Read address, port 1 |
| rd1_data | output | DATA_W | Read data, port 1, one edge after address |

## Verification
The hardest case to reach is a write whose old-value fetch races the other port's commit to the same address. The fetched word is then stale and must be replaced by the bypass inside the write path. The stimulus reaches this case by having port 0 and then port 1 write one address on back-to-back edges, with both read ports watching that address every cycle. A full-rate stream keeps both pipelines busy together, and reads of each just-written address probe the read-side bypass.

// File: rtl/xmp_pkg.sv
package xmp_pkg;

  localparam int XMP_WR_PORTS = 2;
  localparam int XMP_RD_PORTS = 2;

  // Index of the write port whose bank a given port must cancel against.
  function automatic int xmp_peer(input int port);
    return (XMP_WR_PORTS - 1) - port;
  endfunction

endpackage

// File: rtl/xmp_bank_ram.sv
module xmp_bank_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Power-up contents; every copy of a bank must start identical.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read, old data on a same-address collision.
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

endmodule

// File: rtl/xmp_write_stage.sv
module xmp_write_stage #(
  parameter int WIDTH = 16,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic [AW-1:0]    in_addr,
  input  logic [WIDTH-1:0] in_data,
  input  logic [WIDTH-1:0] peer_q,
  input  logic             peer_s1_en,
  input  logic [AW-1:0]    peer_s1_addr,
  input  logic [WIDTH-1:0] peer_enc,
  output logic             s1_en,
  output logic [AW-1:0]    s1_addr,
  output logic [WIDTH-1:0] enc
);

  logic [WIDTH-1:0] s1_data;
  logic             fwd_hit;
  logic [WIDTH-1:0] fwd_val;
  logic [WIDTH-1:0] peer_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_en   <= 1'b0;
      fwd_hit <= 1'b0;
    end else begin
      s1_en   <= in_en;
      fwd_hit <= peer_s1_en && (peer_s1_addr == in_addr);
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= in_addr;
    s1_data <= in_data;
    fwd_val <= peer_enc;
  end

  // Peer commit landing on the same edge as our fetch makes the RAM word stale.
  assign peer_old = fwd_hit ? fwd_val : peer_q;
  assign enc      = s1_data ^ peer_old;

endmodule

// File: rtl/xmp_read_port.sv
module xmp_read_port #(
  parameter int WIDTH = 16,
  parameter int AW    = 6,
  parameter int NB    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            rd_addr,
  input  logic [NB-1:0][WIDTH-1:0] bank_q,
  input  logic [NB-1:0]            s1_en,
  input  logic [NB-1:0][AW-1:0]    s1_addr,
  input  logic [NB-1:0][WIDTH-1:0] enc,
  output logic [WIDTH-1:0]         rd_data
);

  logic [NB-1:0]            hit;
  logic [NB-1:0][WIDTH-1:0] val;
  logic [NB-1:0][WIDTH-1:0] term;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) hit[b] <= 1'b0;
      else     hit[b] <= s1_en[b] && (s1_addr[b] == rd_addr);
    end
    always_ff @(posedge clk) begin
      val[b] <= enc[b];
    end
    assign term[b] = hit[b] ? val[b] : bank_q[b];
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NB; b++) rd_data = rd_data ^ term[b];
  end

endmodule

// File: rtl/xor_mp_mem.sv
module xor_mp_mem #(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr0_en,
  input  logic [ADDR_W-1:0] wr0_addr,
  input  logic [DATA_W-1:0] wr0_data,
  input  logic              wr1_en,
  input  logic [ADDR_W-1:0] wr1_addr,
  input  logic [DATA_W-1:0] wr1_data,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data
);
  import xmp_pkg::*;

  localparam int NW     = XMP_WR_PORTS;
  localparam int NR     = XMP_RD_PORTS;
  localparam int COPIES = NR + 1;

  logic [NW-1:0]              w_en;
  logic [NW-1:0][ADDR_W-1:0]  w_addr;
  logic [NW-1:0][DATA_W-1:0]  w_data;
  logic [NR-1:0][ADDR_W-1:0]  r_addr;
  logic [NR-1:0][DATA_W-1:0]  r_data;

  logic [NW-1:0]              s1_en;
  logic [NW-1:0][ADDR_W-1:0]  s1_addr;
  logic [NW-1:0][DATA_W-1:0]  enc;
  logic [NW-1:0][DATA_W-1:0]  wpath_q;
  logic [NR-1:0][NW-1:0][DATA_W-1:0] rdq;

  assign w_en   = {wr1_en, wr0_en};
  assign w_addr = {wr1_addr, wr0_addr};
  assign w_data = {wr1_data, wr0_data};
  assign r_addr = {rd1_addr, rd0_addr};
  assign rd0_data = r_data[0];
  assign rd1_data = r_data[1];

  // Write pipelines: fetch peer word, then commit encoded word.
  for (genvar k = 0; k < NW; k++) begin : g_wr
    localparam int PEER = xmp_peer(k);
    xmp_write_stage #(.WIDTH(DATA_W), .AW(ADDR_W)) u_stage (
      .clk          (clk),
      .rst          (rst),
      .in_en        (w_en[k]),
      .in_addr      (w_addr[k]),
      .in_data      (w_data[k]),
      .peer_q       (wpath_q[PEER]),
      .peer_s1_en   (s1_en[PEER]),
      .peer_s1_addr (s1_addr[PEER]),
      .peer_enc     (enc[PEER]),
      .s1_en        (s1_en[k]),
      .s1_addr      (s1_addr[k]),
      .enc          (enc[k])
    );
  end

  // Bank groups: one copy per read port plus one read by the peer writer.
  for (genvar b = 0; b < NW; b++) begin : g_bank
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
      if (c < NR) begin : g_rd
        xmp_bank_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH), .AW(ADDR_W)) u_ram (
          .clk   (clk),
          .rst   (rst),
          .we    (s1_en[b]),
          .waddr (s1_addr[b]),
          .wdata (enc[b]),
          .raddr (r_addr[c]),
          .rdata (rdq[c][b])
        );
      end else begin : g_wp
        xmp_bank_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH), .AW(ADDR_W)) u_ram (
          .clk   (clk),
          .rst   (rst),
          .we    (s1_en[b]),
          .waddr (s1_addr[b]),
          .wdata (enc[b]),
          .raddr (w_addr[xmp_peer(b)]),
          .rdata (wpath_q[b])
        );
      end
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_rdp
    xmp_read_port #(.WIDTH(DATA_W), .AW(ADDR_W), .NB(NW)) u_port (
      .clk     (clk),
      .rst     (rst),
      .rd_addr (r_addr[r]),
      .bank_q  (rdq[r]),
      .s1_en   (s1_en),
      .s1_addr (s1_addr),
      .enc     (enc),
      .rd_data (r_data[r])
    );
  end

endmodule

// File: rtl/xmp_checker.sv
module xmp_checker #(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr0_en,
  input logic [ADDR_W-1:0] wr0_addr,
  input logic [DATA_W-1:0] wr0_data,
  input logic              wr1_en,
  input logic [ADDR_W-1:0] wr1_addr,
  input logic [DATA_W-1:0] wr1_data,
  input logic [ADDR_W-1:0] rd0_addr,
  input logic [DATA_W-1:0] rd0_data,
  input logic [ADDR_W-1:0] rd1_addr,
  input logic [DATA_W-1:0] rd1_data
);

  AST_RESET_CLEARS_OUT: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd0_data == '0 && rd1_data == '0)); // R1

  AST_FWD_W0_RD0: assert property (@(posedge clk) disable iff (rst)
    (wr0_en && !(wr1_en && wr1_addr == wr0_addr)) ##1 (rd0_addr == $past(wr0_addr))
    |=> (rd0_data == $past(wr0_data, 2))); // R4

  AST_FWD_W0_RD1: assert property (@(posedge clk) disable iff (rst)
    (wr0_en && !(wr1_en && wr1_addr == wr0_addr)) ##1 (rd1_addr == $past(wr0_addr))
    |=> (rd1_data == $past(wr0_data, 2))); // R4

  AST_FWD_W1_RD0: assert property (@(posedge clk) disable iff (rst)
    (wr1_en && !(wr0_en && wr0_addr == wr1_addr)) ##1 (rd0_addr == $past(wr1_addr))
    |=> (rd0_data == $past(wr1_data, 2))); // R4

  AST_FWD_W1_RD1: assert property (@(posedge clk) disable iff (rst)
    (wr1_en && !(wr0_en && wr0_addr == wr1_addr)) ##1 (rd1_addr == $past(wr1_addr))
    |=> (rd1_data == $past(wr1_data, 2))); // R4

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!wr0_en && !wr1_en) ##1 (!wr0_en && !wr1_en && $stable(rd0_addr))
    |=> $stable(rd0_data)); // R8

endmodule

bind xor_mp_mem xmp_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_xmp_checker (
  .clk      (clk),
  .rst      (rst),
  .wr0_en   (wr0_en),
  .wr0_addr (wr0_addr),
  .wr0_data (wr0_data),
  .wr1_en   (wr1_en),
  .wr1_addr (wr1_addr),
  .wr1_data (wr1_data),
  .rd0_addr (rd0_addr),
  .rd0_data (rd0_data),
  .rd1_addr (rd1_addr),
  .rd1_data (rd1_data)
);

// File: tb/test_xor_mp_mem.sv
module test_xor_mp_mem;

  localparam int DW  = 16;
  localparam int DEP = 64;
  localparam int AW  = $clog2(DEP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr0_en = 1'b0, wr1_en = 1'b0;
  logic [AW-1:0] wr0_addr = '0, wr1_addr = '0, rd0_addr = '0, rd1_addr = '0;
  logic [DW-1:0] wr0_data = '0, wr1_data = '0;
  logic [DW-1:0] rd0_data, rd1_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [DW-1:0] model_mem [DEP];

  always #10 clk = ~clk;

  xor_mp_mem #(.DATA_W(DW), .DEPTH(DEP)) i_xor_mp_mem (
    .clk(clk), .rst(rst),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data)
  );

  typedef struct packed {
    logic          w0e;
    logic [AW-1:0] w0a;
    logic [DW-1:0] w0d;
    logic          w1e;
    logic [AW-1:0] w1a;
    logic [DW-1:0] w1d;
    logic [AW-1:0] r0a;
    logic [AW-1:0] r1a;
    logic [DW-1:0] e0;
    logic [DW-1:0] e1;
    logic [3:0]    tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 6'd1,  16'h1111, 1'b1, 6'd2,  16'h2222, 6'd1,  6'd2,  16'h0000, 16'h0000, 4'd5}, // R5
    '{1'b0, 6'd0,  16'h0000, 1'b0, 6'd0,  16'h0000, 6'd1,  6'd2,  16'h1111, 16'h2222, 4'd4}, // R4
    '{1'b0, 6'd0,  16'h0000, 1'b0, 6'd0,  16'h0000, 6'd2,  6'd1,  16'h2222, 16'h1111, 4'd3}, // R3
    '{1'b1, 6'd1,  16'hAAAA, 1'b1, 6'd3,  16'h3333, 6'd1,  6'd3,  16'h1111, 16'h0000, 4'd5}, // R5
    '{1'b0, 6'd0,  16'h0000, 1'b1, 6'd1,  16'hBBBB, 6'd1,  6'd3,  16'hAAAA, 16'h3333, 4'd7}, // R7
    '{1'b0, 6'd0,  16'h0000, 1'b0, 6'd0,  16'h0000, 6'd1,  6'd1,  16'hBBBB, 16'hBBBB, 4'd7}, // R7
    '{1'b0, 6'd1,  16'hFFFF, 1'b0, 6'd2,  16'hEEEE, 6'd1,  6'd2,  16'hBBBB, 16'h2222, 4'd8}, // R8
    '{1'b0, 6'd0,  16'h0000, 1'b0, 6'd0,  16'h0000, 6'd1,  6'd2,  16'hBBBB, 16'h2222, 4'd8}, // R8
    '{1'b1, 6'd5,  16'h5555, 1'b1, 6'd6,  16'h6666, 6'd5,  6'd6,  16'h0000, 16'h0000, 4'd5}, // R5
    '{1'b1, 6'd6,  16'h0606, 1'b1, 6'd5,  16'h0505, 6'd5,  6'd6,  16'h5555, 16'h6666, 4'd4}, // R4
    '{1'b1, 6'd5,  16'h1234, 1'b1, 6'd6,  16'h4321, 6'd6,  6'd5,  16'h0606, 16'h0505, 4'd4}, // R4
    '{1'b0, 6'd0,  16'h0000, 1'b0, 6'd0,  16'h0000, 6'd5,  6'd6,  16'h1234, 16'h4321, 4'd2}, // R2
    '{1'b1, 6'd63, 16'hFFFF, 1'b1, 6'd0,  16'h0001, 6'd63, 6'd0,  16'h0000, 16'h0000, 4'd9}, // R9
    '{1'b0, 6'd0,  16'h0000, 1'b0, 6'd0,  16'h0000, 6'd63, 6'd0,  16'hFFFF, 16'h0001, 4'd9}  // R9
  };

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                       input int tag, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge; checks outputs after the following rising edge.
  task automatic run_cycle(input logic w0e, input logic [AW-1:0] w0a, input logic [DW-1:0] w0d,
                           input logic w1e, input logic [AW-1:0] w1a, input logic [DW-1:0] w1d,
                           input logic [AW-1:0] r0a, input logic [AW-1:0] r1a,
                           input logic [DW-1:0] e0, input logic [DW-1:0] e1, input int tag);
    wr0_en = w0e; wr0_addr = w0a; wr0_data = w0d;
    wr1_en = w1e; wr1_addr = w1a; wr1_data = w1d;
    rd0_addr = r0a; rd1_addr = r1a;
    @(posedge clk);
    @(negedge clk);
    check(rd0_data, e0, tag, "rd0");
    check(rd1_data, e1, tag, "rd1");
  endtask

  // Expected read = model before this edge's writes (R4/R5 semantics).
  task automatic step(input logic w0e, input logic [AW-1:0] w0a, input logic [DW-1:0] w0d,
                      input logic w1e, input logic [AW-1:0] w1a, input logic [DW-1:0] w1d,
                      input logic [AW-1:0] r0a, input logic [AW-1:0] r1a, input int tag);
    logic [DW-1:0] e0, e1;
    e0 = model_mem[r0a];
    e1 = model_mem[r1a];
    if (w0e) model_mem[w0a] = w0d;
    if (w1e) model_mem[w1a] = w1d;
    run_cycle(w0e, w0a, w0d, w1e, w1a, w1d, r0a, r1a, e0, e1, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    for (int i = 0; i < DEP; i++) model_mem[i] = '0;
    // R1: outputs held at zero while reset is high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rd0_data, '0, 1, "rd0 in reset");
      check(rd1_data, '0, 1, "rd1 in reset");
    end
    rst = 1'b0;
    // R1: unwritten locations read as zero after reset
    step(1'b0, '0, '0, 1'b0, '0, '0, 6'd10, 6'd40, 1);

    // Table walk: R2 R3 R4 R5 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      run_cycle(TBL[v].w0e, TBL[v].w0a, TBL[v].w0d, TBL[v].w1e, TBL[v].w1a, TBL[v].w1d,
                TBL[v].r0a, TBL[v].r1a, TBL[v].e0, TBL[v].e1, int'(TBL[v].tag));
      if (TBL[v].w0e) model_mem[TBL[v].w0a] = TBL[v].w0d;
      if (TBL[v].w1e) model_mem[TBL[v].w1a] = TBL[v].w1d;
    end

    // R1: mid-run reset clears outputs but keeps contents
    rst = 1'b1;
    rd0_addr = 6'd1; rd1_addr = 6'd2;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(rd0_data, '0, 1, "rd0 mid reset");
      check(rd1_data, '0, 1, "rd1 mid reset");
    end
    rst = 1'b0;
    step(1'b0, '0, '0, 1'b0, '0, '0, 6'd1, 6'd2, 1);

    // R7: ports alternate writing one address on consecutive edges
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] d;
      d = DW'(16'h1111 * (i + 1) + 16'h0101);
      if (i % 2 == 0) step(1'b1, 6'd9, d, 1'b0, '0, '0, 6'd9, 6'd9, 7);
      else            step(1'b0, '0, '0, 1'b1, 6'd9, d, 6'd9, 6'd9, 7);
    end
    step(1'b0, '0, '0, 1'b0, '0, '0, 6'd9, 6'd9, 7);

    // R6: both ports write every edge, reads chase the newest writes
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a0, a1, p0;
      a0 = AW'((i * 5) % 32);
      a1 = AW'(32 + (i * 7) % 32);
      p0 = AW'(((i > 0 ? i - 1 : 0) * 5) % 32);
      step(1'b1, a0, DW'(16'hC000 + i), 1'b1, a1, DW'(16'h3000 + i * 3),
           p0, AW'((i * 11) % DEP), 6);
    end

    // R9 / R3: sweep every address on both read ports
    for (int i = 0; i < DEP; i++)
      step(1'b0, '0, '0, 1'b0, '0, '0, AW'(i), AW'(DEP - 1 - i), 9);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R6 watchdog actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule